// File: doc/BRIEF.md
# Two-Channel Compensated DAC Code Bank

This block keeps the codes that feed two 12-bit converters. Each channel has a staging (input) register and a live (output) register, and the live register is what the converter sees. A register write can fill both registers at once. It can fill only the staging register, which is then promoted to the live register by a separate load strobe. It can also hand in a set-point, from which a corrected code is computed once a gain correction K and a temperature offset arrive on that channel's correction port.

The corrected code is `setpoint + round(setpoint * K / 4096) + TEMP`. K is an unsigned fraction with 12 fractional bits, TEMP is a 12-bit two's-complement offset, and the result is clamped to 0..4095. A per-channel configuration word controls two things: whether a correction is needed at all, and whether a finished result goes to the staging register only or to both registers.

Register writes arrive as a valid/ready stream. `wr_ready` is held high, so a beat is taken on every cycle in which `wr_valid` is high and the stream never back-pressures. Each correction port is also valid/ready: `corr_ready[c]` is high only while channel c waits for operands, and a beat completes when valid and ready are both high. Correction data offered while ready is low is not consumed.

Top module: `dac_code_bank`

## Requirements
- R1: After reset every staging and live code is 0, no channel is busy, every config word is 0, and `wr_ready` is 1.
- R2: A write with `wr_op`=0 (direct) loads `wr_data` into both registers of channel `wr_chan`, whatever the config word holds.
- R3: A write with `wr_op`=1 (buffered) changes only the staging register; the live code keeps its value until a load.
- R4: When `ld_strobe` is high, each channel c with `ld_mask[c]`=1 copies its staging register into its live register; channels whose mask bit is 0 keep their live code.
- R5: A write with `wr_op`=3 stores `wr_data[5:0]` as the channel config word: bit 5 selects the destination, bits 4:3 are the temperature mode, bits 2:0 are the K source.
- R6: A set-point write (`wr_op`=2) with K source 000 and temperature mode 00 or 01 stores the set-point unchanged at once, following bit 5, and leaves the channel not busy.
- R7: Any other set-point write makes the channel busy (`busy[c]`=1, `corr_ready[c]`=1). The handshake on `corr_valid[c]` stores setpoint + round(setpoint*K/4096) + TEMP and clears busy.
- R8: A finished set-point result goes to both registers when config bit 5 is 1, and to the staging register only when it is 0.
- R9: A corrected result above 4095 is stored as 4095; a result below 0 is stored as 0.
- R10: A set-point write while busy replaces the pending set-point, and the later completion uses the new value.
- R11: When a result bound for both registers and a load of the same channel fall in one cycle, the live register takes the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write beat valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_chan | input | 1 | Target channel |
| wr_op | input | 2 | 0 direct, 1 buffered, 2 set-point, 3 config |
| wr_data | input | 12 | Code, set-point or config word |
| ld_strobe | input | 1 | Software load pulse |
| ld_mask | input | 2 | Channels promoted by the load |
| corr_valid | input | 2 | Correction beat valid, one per channel |
| corr_ready | output | 2 | Channel waiting for correction |
| corr_k | input | 24 | K per channel, channel c at [12c+:12] |
| corr_temp | input | 24 | TEMP per channel, channel c at [12c+:12] |
| busy | output | 2 | Calculation pending per channel |
| dac_code | output | 24 | Live codes, channel c at [12c+:12] |

## Verification
Every result appears one clock after the edge that takes the stimulus. This applies to a write beat, a load strobe or a correction handshake. `busy` and `corr_ready` rise in the cycle after a set-point write that needs correction, and fall in the cycle after the handshake. The bench drives every input on the falling edge. It holds the input for one rising edge and reads the outputs at the next falling edge, which is the first point at which the registered result is valid. Staging-only results are checked by a later load, or by confirming that the live code stayed unchanged.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_BUFFER = 2'd1,
    OP_SETPT  = 2'd2,
    OP_CONFIG = 2'd3
  } dcb_op_e;

  typedef struct packed {
    logic       both_dest;
    logic [1:0] tmode;
    logic [2:0] ksel;
  } dcb_cfg_t;

  localparam int CFG_W = $bits(dcb_cfg_t);

  function automatic logic needs_corr(dcb_cfg_t c);
    return (c.ksel != 3'd0) || c.tmode[1];
  endfunction
endpackage

// File: rtl/dcb_comp_math.sv
module dcb_comp_math #(
  parameter int W = 12
) (
  input  logic [W-1:0] setpt,
  input  logic [W-1:0] kfrac,
  input  logic [W-1:0] toff,
  output logic [W-1:0] code
);
  localparam int SW = W + 3;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << W) - 1);

  logic [2*W-1:0]        prod;
  logic [2*W-1:0]        prod_rnd;
  logic signed [SW-1:0]  sum;

  always_comb begin
    prod     = {{W{1'b0}}, setpt} * {{W{1'b0}}, kfrac};
    prod_rnd = (prod + (2*W)'(1 << (W-1))) >> W;
    sum      = $signed({3'b000, setpt})
             + $signed(SW'(prod_rnd[W:0]))
             + $signed({{3{toff[W-1]}}, toff});
    if (sum < 0)         code = '0;
    else if (sum > MAXV) code = '1;
    else                 code = sum[W-1:0];
  end
endmodule

// File: rtl/dcb_channel.sv
module dcb_channel
  import dcb_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  dcb_op_e      wr_op,
  input  logic [W-1:0] wr_data,
  input  logic         ld,
  input  logic         corr_valid,
  input  logic [W-1:0] corr_k,
  input  logic [W-1:0] corr_temp,
  output logic         busy,
  output logic [W-1:0] out_code
);
  dcb_cfg_t     cfg_q;
  logic [W-1:0] sp_q, in_q, out_q;
  logic         busy_q;
  logic [W-1:0] res;
  logic         bypass, done;

  dcb_comp_math #(.W(W)) u_math (
    .setpt(sp_q), .kfrac(corr_k), .toff(corr_temp), .code(res)
  );

  assign bypass   = !needs_corr(cfg_q);
  assign done     = busy_q && corr_valid;
  assign busy     = busy_q;
  assign out_code = out_q;

  // Later assignments win: load < calculation result < register write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sp_q   <= '0;
      in_q   <= '0;
      out_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (ld) out_q <= in_q;
      if (done) begin
        in_q   <= res;
        busy_q <= 1'b0;
        if (cfg_q.both_dest) out_q <= res;
      end
      if (wr_en) begin
        unique case (wr_op)
          OP_DIRECT: begin
            in_q  <= wr_data;
            out_q <= wr_data;
          end
          OP_BUFFER: in_q <= wr_data;
          OP_SETPT: begin
            if (bypass) begin
              in_q   <= wr_data;
              busy_q <= 1'b0;
              if (cfg_q.both_dest) out_q <= wr_data;
            end else begin
              sp_q   <= wr_data;
              busy_q <= 1'b1;
            end
          end
          OP_CONFIG: cfg_q <= dcb_cfg_t'(wr_data[CFG_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  logic wr_hits_out;
  assign wr_hits_out = wr_en && (wr_op == OP_DIRECT ||
                       (wr_op == OP_SETPT && bypass && cfg_q.both_dest));

  a_r2_direct_both: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_op == OP_DIRECT |=> out_q == $past(wr_data) && in_q == $past(wr_data));

  a_r3_buffer_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_op == OP_BUFFER && !ld && !done |=> $stable(out_q));

  a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    ld && !done && !wr_hits_out |=> out_q == $past(in_q));

  a_r6_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_op == OP_SETPT && bypass |=> !busy_q && in_q == $past(wr_data));

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_op == OP_SETPT && !bypass |=> busy_q);

  a_r11_result_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done && cfg_q.both_dest && ld && !wr_hits_out |=> out_q == $past(res));
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
  import dcb_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NCH    = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [CH_W-1:0]       wr_chan,
  input  logic [1:0]            wr_op,
  input  logic [CODE_W-1:0]     wr_data,
  input  logic                  ld_strobe,
  input  logic [NCH-1:0]        ld_mask,
  input  logic [NCH-1:0]        corr_valid,
  output logic [NCH-1:0]        corr_ready,
  input  logic [NCH*CODE_W-1:0] corr_k,
  input  logic [NCH*CODE_W-1:0] corr_temp,
  output logic [NCH-1:0]        busy,
  output logic [NCH*CODE_W-1:0] dac_code
);
  assign wr_ready = 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_valid && (wr_chan == CH_W'(c));

    dcb_channel #(.W(CODE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ch_wr),
      .wr_op     (dcb_op_e'(wr_op)),
      .wr_data   (wr_data),
      .ld        (ld_strobe && ld_mask[c]),
      .corr_valid(corr_valid[c]),
      .corr_k    (corr_k[c*CODE_W +: CODE_W]),
      .corr_temp (corr_temp[c*CODE_W +: CODE_W]),
      .busy      (busy[c]),
      .out_code  (dac_code[c*CODE_W +: CODE_W])
    );

    assign corr_ready[c] = busy[c];

    a_r4_unmasked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe && !ld_mask[c] && !ch_wr && !corr_valid[c] |=> $stable(dac_code[c*CODE_W +: CODE_W]));
  end
endmodule

// File: tb/dac_code_bank_bench.sv
module dac_code_bank_bench;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [0:0]  wr_chan = '0;
  logic [1:0]  wr_op = '0;
  logic [11:0] wr_data = '0;
  logic        ld_strobe = 1'b0;
  logic [1:0]  ld_mask = '0;
  logic [1:0]  corr_valid = '0;
  logic [1:0]  corr_ready;
  logic [23:0] corr_k = '0;
  logic [23:0] corr_temp = '0;
  logic [1:0]  busy;
  logic [23:0] dac_code;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dac_code_bank u_dac_code_bank (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_op(wr_op), .wr_data(wr_data),
    .ld_strobe(ld_strobe), .ld_mask(ld_mask),
    .corr_valid(corr_valid), .corr_ready(corr_ready),
    .corr_k(corr_k), .corr_temp(corr_temp),
    .busy(busy), .dac_code(dac_code)
  );

  // cfg, setpoint, K, TEMP, expected code (config bit 5 set: lands on live)
  localparam logic [6*12-1:0] VEC [6] = '{
    {12'h021, 12'd1000, 12'd2048, 12'h000, 12'd1500, 12'd0},
    {12'h021, 12'd1000, 12'd0,    12'hF9C, 12'd900,  12'd0},
    {12'h030, 12'd4000, 12'd1024, 12'h000, 12'd4095, 12'd0},
    {12'h022, 12'd10,   12'd0,    12'hFCE, 12'd0,    12'd0},
    {12'h023, 12'd3,    12'd2048, 12'h000, 12'd5,    12'd0},
    {12'h027, 12'd2047, 12'd4095, 12'hFF9, 12'd4087, 12'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int op, input int data);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 1'(ch); wr_op = 2'(op); wr_data = 12'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic corr(input int ch, input int k, input int t);
    @(negedge clk);
    corr_valid[ch] = 1'b1;
    corr_k[ch*12 +: 12] = 12'(k);
    corr_temp[ch*12 +: 12] = 12'(t);
    @(negedge clk);
    corr_valid = '0;
  endtask

  task automatic load(input int mask);
    @(negedge clk);
    ld_strobe = 1'b1; ld_mask = 2'(mask);
    @(negedge clk);
    ld_strobe = 1'b0; ld_mask = '0;
  endtask

  function automatic logic [11:0] code(input int ch);
    return dac_code[ch*12 +: 12];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state (held in reset)
    chk("R1 code0", code(0), 0);
    chk("R1 code1", code(1), 0);
    chk("R1 busy", busy, 0);
    chk("R1 wr_ready", wr_ready, 1);
    rst_n = 1'b1;

    // Vector table: R5 config, R7 compute, R8 both, R9 clamp
    for (int i = 0; i < 6; i++) begin
      logic [6*12-1:0] v;
      v = VEC[i];
      wr(0, 3, v[71:60]);
      wr(0, 2, v[59:48]);
      chk("R7 busy after setpoint", busy[0], 1);
      chk("R7 corr_ready", corr_ready[0], 1);
      corr(0, v[47:36], v[35:24]);
      chk("R7 R9 corrected code", code(0), v[23:12]);
      chk("R7 busy cleared", busy[0], 0);
    end

    // R2 direct write ignores config
    wr(1, 3, 12'h000);
    wr(1, 0, 777);
    chk("R2 direct ch1", code(1), 777);
    chk("R2 ch0 untouched", code(0), 4087);

    // R3 buffered: live unchanged
    wr(1, 1, 123);
    chk("R3 live held", code(1), 777);
    wr(0, 1, 456);
    // R4 load only ch1
    load(2);
    chk("R4 ch1 promoted", code(1), 123);
    chk("R4 ch0 unmasked held", code(0), 4087);
    load(1);
    chk("R4 ch0 promoted", code(0), 456);

    // R6 bypass, bit5=1, temp mode 01
    wr(0, 3, 12'h028);
    wr(0, 2, 3000);
    chk("R6 bypass live", code(0), 3000);
    chk("R6 bypass not busy", busy[0], 0);
    // R6 bypass, bit5=0 -> staging only
    wr(0, 3, 12'h008);
    wr(0, 2, 2222);
    chk("R6 R8 staging only", code(0), 3000);
    chk("R6 not busy", busy[0], 0);
    load(1);
    chk("R6 staging via load", code(0), 2222);

    // R8 corrected with bit5=0: live held until load
    wr(1, 3, 12'h001);
    wr(1, 2, 100);
    corr(1, 0, 5);
    chk("R8 live held", code(1), 123);
    load(2);
    chk("R8 staging result", code(1), 105);

    // R10 replace pending setpoint
    wr(1, 3, 12'h021);
    wr(1, 2, 50);
    wr(1, 2, 60);
    chk("R10 still busy", busy[1], 1);
    corr(1, 0, 0);
    chk("R10 new setpoint used", code(1), 60);

    // correction offered while not busy is ignored (R7)
    corr(1, 0, 100);
    chk("R7 idle corr ignored", code(1), 60);

    // R11 result beats load on same cycle
    wr(1, 1, 999);
    wr(1, 2, 200);
    @(negedge clk);
    ld_strobe = 1'b1; ld_mask = 2'b10;
    corr_valid[1] = 1'b1; corr_k[23:12] = 12'd0; corr_temp[23:12] = 12'd1;
    @(negedge clk);
    ld_strobe = 1'b0; ld_mask = '0; corr_valid = '0;
    chk("R11 result wins", code(1), 201);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule